// File: doc/BRIEF.md
# Sleep and Event Wake Controller

This block holds the sleep-entry and wake decisions for a small processor core. The core's decoder hands it one-cycle strobes for the wait-for-event, wait-for-interrupt and send-event instructions. It also hands it a strobe for an exception return that lands in thread mode. The block answers with a registered sleep status, a deep-sleep status, a one-cycle wake pulse and a one-cycle retire pulse. The retire pulse tells the core that it may complete the sleep instruction and move on. A send-event instruction also produces a one-cycle transmit-event pulse for neighbouring cores or peripherals.

A single event latch collects every event source: the local send-event instruction, the external receive-event input, and, when enabled, interrupt lines that go from not-pending to pending. A wait-for-event that finds an event already recorded does not sleep. It consumes the event and retires at once. This closes the race between software testing a flag and going to sleep. Wait-for-interrupt sleep ignores the latch. Only an enabled interrupt of sufficient priority, or a debug request, ends it. A word-only control register selects normal or deep sleep, automatic sleep on return to thread mode, and wake on newly pending interrupts.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, every output is 0, the control register reads 0 and the event latch is empty, so a first wait-for-event enters sleep.
- R2: A write with size code 2 (word) stores bit 1 (sleep on exit), bit 2 (deep select) and bit 4 (wake on new pend). Every other bit reads back as zero, and cfg_err stays 0.
- R3: A write with size code 0, 1 or 3 leaves the register unchanged and raises cfg_err for exactly the following cycle.
- R4: A wait-for-event strobe seen while the event latch is set, or while an event arrives in the same cycle, does not enter sleep. It clears the latch and pulses sleep_retire in the next cycle.
- R5: A wait-for-event strobe with the latch empty, or any wait-for-interrupt strobe, raises sleep_active in the next cycle. deep_sleep also rises when bit 2 was set at entry, and it falls with sleep_active.
- R6: A cycle with rxev_in high sets the event latch while awake and ends wait-for-event sleep.
- R7: A send-event strobe gives txev_out high for exactly the next cycle and sets the event latch.
- R8: With bit 4 set, any interrupt line going from 0 to 1 on irq_pend is an event, even when its irq_en bit is 0. A line that is already high causes no new event. With bit 4 clear, such edges cause no event.
- R9: Wait-for-interrupt sleep is entered even with the latch set. Events do not end it; they still set the latch. It ends only on a pending line whose irq_en is set, or on dbg_req.
- R10: An exc_ret_thread strobe with bit 1 set enters sleep. The wake that ends that sleep pulses wake_pulse but not sleep_retire. With bit 1 clear the strobe has no effect on sleep_active.
- R11: sleep_active falls in the first cycle after a wake condition is sampled. wake_pulse is high for that one cycle. A wake from instruction-entered sleep also pulses sleep_retire, and a wake from wait-for-event sleep leaves the latch empty.
- R12: An enabled pending interrupt or dbg_req ends wait-for-event sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_size | input | 2 | Transfer size: 0 byte, 1 half, 2 word, 3 reserved |
| cfg_wr_data | input | DATA_W | Write data |
| cfg_rd_data | output | DATA_W | Control register read value |
| cfg_err | output | 1 | Error response for a rejected write |
| wfe_strobe | input | 1 | Decoded wait-for-event |
| wfi_strobe | input | 1 | Decoded wait-for-interrupt |
| sev_strobe | input | 1 | Decoded send-event |
| exc_ret_thread | input | 1 | Exception return to thread mode |
| dbg_req | input | 1 | Halt debug request |
| rxev_in | input | 1 | External receive-event |
| irq_pend | input | NUM_IRQ | Per-interrupt pending status |
| irq_en | input | NUM_IRQ | Per-interrupt enabled with enough priority to wake |
| sleep_active | output | 1 | Core is asleep |
| deep_sleep | output | 1 | Sleep is the deep kind |
| txev_out | output | 1 | Transmit-event pulse |
| wake_pulse | output | 1 | One-cycle wake indication |
| sleep_retire | output | 1 | Sleep instruction may retire |

## Verification
The bench builds the block with NUM_IRQ = 4 and DATA_W = 32. This makes an exhaustive sweep possible over every interrupt line, both enable states, both settings of the wake-on-pend bit and both sleep instructions. It checks each wake-or-stay outcome and probes the latch left behind. The five low control bits are swept against all four size codes, so every stored and every rejected write is seen. Directed sequences cover the already-pending line, receive-event, send-event, deep selection and sleep on exit.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_WFE = 2'd1,
    ST_WFI = 2'd2
  } swc_state_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } swc_size_e;

  localparam int BIT_SOE  = 1;
  localparam int BIT_DEEP = 2;
  localparam int BIT_SOP  = 4;

  typedef struct packed {
    logic sop;
    logic deep;
    logic soe;
  } swc_cfg_t;
endpackage

// File: rtl/swc_ctrl_reg.sv
module swc_ctrl_reg
  import swc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  output swc_cfg_t          cfg,
  output logic [DATA_W-1:0] rd_data,
  output logic              err
);
  swc_cfg_t cfg_q;
  logic     word_ok;
  logic     unused_bits;

  assign word_ok     = (wr_size == SZ_WORD);
  assign unused_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      err   <= 1'b0;
    end else begin
      err <= wr_en && !word_ok;
      if (wr_en && word_ok) begin
        cfg_q.soe  <= wr_data[BIT_SOE];
        cfg_q.deep <= wr_data[BIT_DEEP];
        cfg_q.sop  <= wr_data[BIT_SOP];
      end
    end
  end

  always_comb begin
    rd_data           = '0;
    rd_data[BIT_SOE]  = cfg_q.soe;
    rd_data[BIT_DEEP] = cfg_q.deep;
    rd_data[BIT_SOP]  = cfg_q.sop;
  end

  assign cfg = cfg_q;

  // R3: a rejected write keeps the stored bits and flags an error next cycle
  a_r3_bad_write_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !word_ok) |=> ($stable(cfg_q) && err));
  a_r2_good_write_no_err: assert property (@(posedge clk) disable iff (rst)
    (wr_en && word_ok) |=> !err);
endmodule

// File: rtl/swc_event_src.sv
module swc_event_src #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sop_en,
  input  logic               sev,
  input  logic               rxev,
  input  logic [NUM_IRQ-1:0] irq_pend,
  output logic               txev,
  output logic               ev_now
);
  logic [NUM_IRQ-1:0] pend_prev;
  logic [NUM_IRQ-1:0] pend_rise;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) pend_prev[g] <= 1'b0;
      else     pend_prev[g] <= irq_pend[g];
    end
    assign pend_rise[g] = irq_pend[g] && !pend_prev[g];
  end

  always_ff @(posedge clk) begin
    if (rst) txev <= 1'b0;
    else     txev <= sev;
  end

  assign ev_now = sev || rxev || (sop_en && (|pend_rise));

  // R7: transmit pulse follows each send-event strobe and has no other cause
  a_r7_txev_follows: assert property (@(posedge clk) disable iff (rst)
    sev |=> txev);
  a_r7_txev_cause: assert property (@(posedge clk) disable iff (rst)
    txev |-> $past(sev));
endmodule

// File: rtl/swc_sleep_fsm.sv
module swc_sleep_fsm
  import swc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  swc_cfg_t cfg,
  input  logic     wfe,
  input  logic     wfi,
  input  logic     exc_ret,
  input  logic     ev_now,
  input  logic     irq_wake,
  input  logic     dbg,
  output logic     sleeping,
  output logic     deep,
  output logic     wake,
  output logic     retire
);
  swc_state_e state;
  logic       ev_q;
  logic       by_exit;
  logic       deep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RUN;
      ev_q    <= 1'b0;
      by_exit <= 1'b0;
      deep_q  <= 1'b0;
      wake    <= 1'b0;
      retire  <= 1'b0;
    end else begin
      wake   <= 1'b0;
      retire <= 1'b0;
      case (state)
        ST_RUN: begin
          if (wfe) begin
            if (ev_q || ev_now) begin
              ev_q   <= 1'b0;
              retire <= 1'b1;
            end else begin
              state  <= ST_WFE;
              deep_q <= cfg.deep;
            end
          end else if (wfi) begin
            state   <= ST_WFI;
            by_exit <= 1'b0;
            deep_q  <= cfg.deep;
            ev_q    <= ev_q || ev_now;
          end else if (exc_ret && cfg.soe) begin
            state   <= ST_WFI;
            by_exit <= 1'b1;
            deep_q  <= cfg.deep;
            ev_q    <= ev_q || ev_now;
          end else begin
            ev_q <= ev_q || ev_now;
          end
        end
        ST_WFE: begin
          if (ev_now || irq_wake || dbg) begin
            state  <= ST_RUN;
            ev_q   <= 1'b0;
            deep_q <= 1'b0;
            wake   <= 1'b1;
            retire <= 1'b1;
          end
        end
        ST_WFI: begin
          ev_q <= ev_q || ev_now;
          if (irq_wake || dbg) begin
            state  <= ST_RUN;
            deep_q <= 1'b0;
            wake   <= 1'b1;
            retire <= !by_exit;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign sleeping = (state != ST_RUN);
  assign deep     = deep_q;

  // R4: a recorded event turns wait-for-event into an immediate retire
  a_r4_latch_skips_sleep: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && wfe && ev_q) |=> (state == ST_RUN && retire && !ev_q));
  // R9: wait-for-interrupt sleep persists without an enabled interrupt or debug
  a_r9_wfi_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WFI && !irq_wake && !dbg) |=> (state == ST_WFI));
  // R11 / R12: a wake condition ends sleep in the following cycle
  a_r11_sleep_drops: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN && (irq_wake || dbg)) |=> (state == ST_RUN && wake));
  a_r11_wake_single: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake);
  // R5: deep status only while asleep
  a_r5_deep_asleep: assert property (@(posedge clk) disable iff (rst)
    deep_q |-> (state != ST_RUN));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr_en,
  input  logic [1:0]         cfg_wr_size,
  input  logic [DATA_W-1:0]  cfg_wr_data,
  output logic [DATA_W-1:0]  cfg_rd_data,
  output logic               cfg_err,
  input  logic               wfe_strobe,
  input  logic               wfi_strobe,
  input  logic               sev_strobe,
  input  logic               exc_ret_thread,
  input  logic               dbg_req,
  input  logic               rxev_in,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic               sleep_active,
  output logic               deep_sleep,
  output logic               txev_out,
  output logic               wake_pulse,
  output logic               sleep_retire
);
  swc_cfg_t cfg;
  logic     ev_now;
  logic     irq_wake;

  assign irq_wake = |(irq_pend & irq_en);

  swc_ctrl_reg #(.DATA_W(DATA_W)) reg_i (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_size(cfg_wr_size),
    .wr_data(cfg_wr_data), .cfg(cfg), .rd_data(cfg_rd_data), .err(cfg_err)
  );

  swc_event_src #(.NUM_IRQ(NUM_IRQ)) evt_i (
    .clk(clk), .rst(rst), .sop_en(cfg.sop), .sev(sev_strobe), .rxev(rxev_in),
    .irq_pend(irq_pend), .txev(txev_out), .ev_now(ev_now)
  );

  swc_sleep_fsm fsm_i (
    .clk(clk), .rst(rst), .cfg(cfg), .wfe(wfe_strobe), .wfi(wfi_strobe),
    .exc_ret(exc_ret_thread), .ev_now(ev_now), .irq_wake(irq_wake),
    .dbg(dbg_req), .sleeping(sleep_active), .deep(deep_sleep),
    .wake(wake_pulse), .retire(sleep_retire)
  );

  // R10: automatic sleep on thread return needs the enable bit
  a_r10_exit_needs_bit: assert property (@(posedge clk) disable iff (rst)
    (!sleep_active && exc_ret_thread && !wfe_strobe && !wfi_strobe && !cfg.soe)
      |=> !sleep_active);
endmodule

// File: tb/sleep_wake_ctrl_tb_top.sv
module sleep_wake_ctrl_tb_top;
  localparam int NI = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr_en = 1'b0;
  logic [1:0]    cfg_wr_size = 2'd0;
  logic [DW-1:0] cfg_wr_data = '0;
  logic [DW-1:0] cfg_rd_data;
  logic          cfg_err;
  logic          wfe_strobe = 1'b0, wfi_strobe = 1'b0, sev_strobe = 1'b0;
  logic          exc_ret_thread = 1'b0, dbg_req = 1'b0, rxev_in = 1'b0;
  logic [NI-1:0] irq_pend = '0, irq_en = '0;
  logic          sleep_active, deep_sleep, txev_out, wake_pulse, sleep_retire;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  sleep_wake_ctrl #(.NUM_IRQ(NI), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_size(cfg_wr_size),
    .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data), .cfg_err(cfg_err),
    .wfe_strobe(wfe_strobe), .wfi_strobe(wfi_strobe), .sev_strobe(sev_strobe),
    .exc_ret_thread(exc_ret_thread), .dbg_req(dbg_req), .rxev_in(rxev_in),
    .irq_pend(irq_pend), .irq_en(irq_en), .sleep_active(sleep_active),
    .deep_sleep(deep_sleep), .txev_out(txev_out), .wake_pulse(wake_pulse),
    .sleep_retire(sleep_retire)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; irq_pend = '0; irq_en = '0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic wr(input logic [31:0] v, input logic [1:0] sz);
    cfg_wr_en = 1'b1; cfg_wr_data = v; cfg_wr_size = sz;
    tick();
    cfg_wr_en = 1'b0;
  endtask

  task automatic p_wfe(); wfe_strobe = 1'b1; tick(); wfe_strobe = 1'b0; endtask
  task automatic p_wfi(); wfi_strobe = 1'b1; tick(); wfi_strobe = 1'b0; endtask
  task automatic p_sev(); sev_strobe = 1'b1; tick(); sev_strobe = 1'b0; endtask
  task automatic p_rx();  rxev_in = 1'b1; tick(); rxev_in = 1'b0; endtask
  task automatic p_dbg(); dbg_req = 1'b1; tick(); dbg_req = 1'b0; endtask
  task automatic p_exit(); exc_ret_thread = 1'b1; tick(); exc_ret_thread = 1'b0; endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] exp_reg;
    do_reset();
    // R1: reset state
    chk("R1 sleep", {31'd0, sleep_active}, 0);
    chk("R1 deep", {31'd0, deep_sleep}, 0);
    chk("R1 txev", {31'd0, txev_out}, 0);
    chk("R1 wake", {31'd0, wake_pulse}, 0);
    chk("R1 retire", {31'd0, sleep_retire}, 0);
    chk("R1 reg", cfg_rd_data, 0);
    chk("R1 err", {31'd0, cfg_err}, 0);
    p_wfe();
    chk("R1 latch empty", {31'd0, sleep_active}, 1);
    p_dbg();
    chk("R12 dbg wake", {31'd0, sleep_active}, 0);

    // R2 / R3: register sweep over low bits and all size codes
    exp_reg = 0;
    for (int v = 0; v < 32; v++) begin
      for (int sz = 0; sz < 4; sz++) begin
        wr(32'hFFFF_FFE0 | v, sz[1:0]);
        if (sz == 2) exp_reg = v & 32'h16;
        chk(sz == 2 ? "R2 readback" : "R3 readback", cfg_rd_data, exp_reg);
        chk(sz == 2 ? "R2 err" : "R3 err", {31'd0, cfg_err}, (sz == 2) ? 0 : 1);
        tick();
        chk("R3 err single", {31'd0, cfg_err}, 0);
      end
    end

    // Sweep: line, enable, wake-on-pend bit, sleep instruction
    for (int mode = 0; mode < 2; mode++) begin
      for (int sop = 0; sop < 2; sop++) begin
        for (int en = 0; en < 2; en++) begin
          for (int i = 0; i < NI; i++) begin
            bit wk;
            bit lat;
            do_reset();
            wr(sop << 4, 2'd2);
            irq_en = en ? (NI'(1) << i) : '0;
            if (mode == 0) p_wfe(); else p_wfi();
            chk("R5 enter", {31'd0, sleep_active}, 1);
            irq_pend = NI'(1) << i;
            tick();
            irq_pend = '0;
            wk  = (en == 1) || (mode == 0 && sop == 1);
            lat = (mode == 1) && (sop == 1);
            chk(mode == 0 ? "R8/R12 wfe wake" : "R9 wfi wake", {31'd0, sleep_active}, !wk);
            chk("R11 wake pulse", {31'd0, wake_pulse}, wk);
            chk("R11 retire", {31'd0, sleep_retire}, wk);
            if (!wk) begin
              p_dbg();
              chk("R11 dbg wake", {31'd0, sleep_active}, 0);
            end
            p_wfe();
            chk(mode == 0 ? "R11 latch clear" : "R9 latch kept", {31'd0, sleep_active}, !lat);
            if (!lat) p_dbg();
          end
        end
      end
    end

    // R5: deep select
    do_reset();
    wr(32'h4, 2'd2);
    p_wfe();
    chk("R5 deep", {31'd0, deep_sleep}, 1);
    p_dbg();
    chk("R5 deep drops", {31'd0, deep_sleep}, 0);
    wr(32'h0, 2'd2);
    p_wfi();
    chk("R5 normal", {30'd0, sleep_active, deep_sleep}, 2);
    p_dbg();

    // R6: receive event
    p_wfe();
    p_rx();
    chk("R6 rx wake", {30'd0, sleep_active, wake_pulse}, 1);
    p_rx();
    p_wfe();
    chk("R6 latch set", {30'd0, sleep_active, sleep_retire}, 1);
    p_wfe();
    chk("R4 consumed", {31'd0, sleep_active}, 1);
    p_dbg();

    // R7: send event
    p_sev();
    chk("R7 txev high", {31'd0, txev_out}, 1);
    tick();
    chk("R7 txev low", {31'd0, txev_out}, 0);
    p_wfe();
    chk("R7 latch", {31'd0, sleep_active}, 0);

    // R4: event in same cycle as wait-for-event
    wfe_strobe = 1'b1; rxev_in = 1'b1; tick(); wfe_strobe = 1'b0; rxev_in = 1'b0;
    chk("R4 same cycle", {30'd0, sleep_active, sleep_retire}, 1);

    // R8: already pending line
    wr(32'h10, 2'd2);
    irq_pend = 4'b0100;
    tick();
    p_wfe();
    chk("R8 new pend event", {31'd0, sleep_active}, 0);
    p_wfe();
    chk("R8 old pend quiet", {31'd0, sleep_active}, 1);
    tick(); tick();
    chk("R8 still asleep", {31'd0, sleep_active}, 1);
    p_dbg();
    irq_pend = '0;
    tick();

    // R9: set latch does not stop wait-for-interrupt; events do not end it
    p_rx();
    p_wfi();
    chk("R9 sleeps with latch", {31'd0, sleep_active}, 1);
    p_rx();
    chk("R9 event ignored", {31'd0, sleep_active}, 1);
    p_dbg();
    p_wfe();
    chk("R9 latch kept", {31'd0, sleep_active}, 0);

    // R10: sleep on exit
    wr(32'h2, 2'd2);
    p_exit();
    chk("R10 exit sleep", {31'd0, sleep_active}, 1);
    irq_en = 4'b0001; irq_pend = 4'b0001;
    tick();
    irq_pend = '0;
    chk("R10 wake", {29'd0, sleep_active, wake_pulse, sleep_retire}, 2);
    wr(32'h0, 2'd2);
    p_exit();
    chk("R10 bit clear", {31'd0, sleep_active}, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule